// File: doc/BRIEF.md
# Indirect Table Access Port

This block gives software access to several internal lookup tables through two 64-bit registers. An address register holds an entry index, a table-select code and an auto-increment flag. A data register is a window onto the entry that the address register points at. A data read returns that entry and a data write replaces it. When the auto-increment flag is set, every data access that reaches a known table moves the index to the next entry. The index wraps at the depth of the selected table, and the new index is visible in the address register.

Two of the tables have side effects on a write. A write to the interrupt-vector table keeps only its routing fields and emits a strobe carrying the entry index, priority and server number. A write to the 64-bit window table emits a strobe that tells downstream logic to recheck the window at that index. A select code that names a known but unbuilt table reads as zero. A select code that names nothing at all raises an error pulse and the access does nothing.

Top module: `itap_top`

## Requirements
- R1: After reset the address register reads as zero, `acc_rdata` is zero, and `ivt_upd_o`, `win_upd_o` and `sel_err_o` are low.
- R2: A write with `acc_sel`=0 loads the address register as follows: index = bits [7:0], table select = bits [19:16], auto-increment = bit 31. A read with `acc_sel`=0 returns these fields in the same positions, with every other bit zero.
- R3: Table select 0 (general, 8 entries) and table select 4 (window, 16 entries) store a data write and return it on a later data read. The entry used is the index ANDed with (depth-1).
- R4: After a data access to a known table (select 0 to 4) with auto-increment set, the index becomes (index+1) AND (depth-1) of that table. With auto-increment clear, the index is unchanged.
- R5: Select codes 2 and 3 are known tables that are not built, each 4 entries deep. A data read of either returns all zeros and a data write to either stores nothing.
- R6: A data access with a select code of 5 or above makes `sel_err_o` high for exactly one cycle, one cycle after the access. Such an access leaves the index unchanged, writes nothing and reads as zero.
- R7: Table select 1 (interrupt vectors, 8 entries) stores only server [47:32], priority [15:8] and node [23:20] of a write. All other bits read back as zero.
- R8: A data write to table 1 makes `ivt_upd_o` high for one cycle, in the cycle the entry is updated. In that cycle `ivt_idx_o` holds the masked index, `ivt_server_o` holds write bits [47:34] (the server number shifted right by 2) and `ivt_prio_o` holds bits [15:8].
- R9: A data write to table 4 makes `win_upd_o` high for one cycle, in the cycle the entry is updated, with the masked index on `win_idx_o`.
- R10: Neither strobe fires on a data read, on an address-register access, or on a write to any other table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = address register, 1 = data register |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, registered, valid the cycle after a read |
| sel_err_o | output | 1 | Pulse: unknown table select on a data access |
| ivt_upd_o | output | 1 | Pulse: interrupt-vector entry written |
| ivt_idx_o | output | 8 | Index of written interrupt-vector entry |
| ivt_server_o | output | 14 | Server number with the link-pointer bits dropped |
| ivt_prio_o | output | 8 | Priority of written entry |
| win_upd_o | output | 1 | Pulse: window entry written, recheck needed |
| win_idx_o | output | 8 | Index of written window entry |

## Verification
The hardest case to reach from the ports is the interplay between auto-increment wrap and table switching. An index that is legal for the 16-entry window table is out of range for the 4-entry unbuilt tables, and a run of accesses must carry it across the wrap point of each. The stimulus reloads the address register at random with select codes that span the known, unbuilt and unknown ranges, random indices and random auto-increment. It then issues long runs of data reads and writes against a bench model of every table. Directed sequences start the index one below each wrap point and also cover unknown select codes with auto-increment set.

// File: rtl/itap_pkg.sv
package itap_pkg;
  localparam int IDX_W    = 8;
  localparam int SEL_W    = 4;
  localparam int SEL_LSB  = 16;
  localparam int AINC_BIT = 31;
  localparam int SRV_LSB  = 32;
  localparam int SRV_W    = 16;
  localparam int PRI_LSB  = 8;
  localparam int PRI_W    = 8;
  localparam int NODE_LSB = 20;
  localparam int NODE_W   = 4;
  localparam int SRVO_W   = SRV_W - 2;

  typedef enum logic [SEL_W-1:0] {
    TBL_GEN   = 4'd0,
    TBL_IVT   = 4'd1,
    TBL_STUBA = 4'd2,
    TBL_STUBB = 4'd3,
    TBL_WIN   = 4'd4
  } tbl_e;

  // Keep only the routing fields of an interrupt-vector entry
  function automatic logic [63:0] ivt_keep(input logic [63:0] d);
    logic [63:0] m;
    m = '0;
    m[SRV_LSB +: SRV_W]   = '1;
    m[PRI_LSB +: PRI_W]   = '1;
    m[NODE_LSB +: NODE_W] = '1;
    return d & m;
  endfunction

  function automatic logic [IDX_W-1:0] idx_advance(input logic [IDX_W-1:0] idx,
                                                   input logic [IDX_W-1:0] mask);
    return (idx + IDX_W'(1)) & mask;
  endfunction

  function automatic logic [63:0] addr_image(input logic [IDX_W-1:0] idx,
                                             input logic [SEL_W-1:0] tsel,
                                             input logic ainc);
    logic [63:0] v;
    v = '0;
    v[IDX_W-1:0]             = idx;
    v[SEL_LSB +: SEL_W]      = tsel;
    v[AINC_BIT]              = ainc;
    return v;
  endfunction
endpackage

// File: rtl/itap_decode.sv
module itap_decode
  import itap_pkg::*;
#(
  parameter int GEN_DEPTH  = 8,
  parameter int IVT_DEPTH  = 8,
  parameter int STUB_DEPTH = 4,
  parameter int WIN_DEPTH  = 16
) (
  input  logic [SEL_W-1:0] tsel,
  output logic             known,
  output logic             hit_gen,
  output logic             hit_ivt,
  output logic             hit_win,
  output logic [IDX_W-1:0] mask
);
  always_comb begin
    known   = 1'b1;
    hit_gen = 1'b0;
    hit_ivt = 1'b0;
    hit_win = 1'b0;
    mask    = '0;
    case (tsel)
      TBL_GEN:   begin hit_gen = 1'b1; mask = IDX_W'(GEN_DEPTH - 1); end
      TBL_IVT:   begin hit_ivt = 1'b1; mask = IDX_W'(IVT_DEPTH - 1); end
      TBL_STUBA,
      TBL_STUBB: mask = IDX_W'(STUB_DEPTH - 1);
      TBL_WIN:   begin hit_win = 1'b1; mask = IDX_W'(WIN_DEPTH - 1); end
      default:   known = 1'b0;
    endcase
  end
endmodule

// File: rtl/itap_bank.sv
module itap_bank #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [63:0]   wdata,
  output logic [63:0]   rdata
);
  logic [63:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                        mem[g] <= '0;
      else if (we && idx == AW'(g))      mem[g] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/itap_top.sv
module itap_top
  import itap_pkg::*;
#(
  parameter int GEN_DEPTH  = 8,
  parameter int IVT_DEPTH  = 8,
  parameter int STUB_DEPTH = 4,
  parameter int WIN_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_sel,
  input  logic [63:0]       acc_wdata,
  output logic [63:0]       acc_rdata,
  output logic              sel_err_o,
  output logic              ivt_upd_o,
  output logic [IDX_W-1:0]  ivt_idx_o,
  output logic [SRVO_W-1:0] ivt_server_o,
  output logic [PRI_W-1:0]  ivt_prio_o,
  output logic              win_upd_o,
  output logic [IDX_W-1:0]  win_idx_o
);
  localparam int GEN_AW = $clog2(GEN_DEPTH);
  localparam int IVT_AW = $clog2(IVT_DEPTH);
  localparam int WIN_AW = $clog2(WIN_DEPTH);

  logic [IDX_W-1:0] idx_q;
  logic [SEL_W-1:0] tsel_q;
  logic             ainc_q;

  logic             known, hit_gen, hit_ivt, hit_win;
  logic [IDX_W-1:0] mask, ent;
  logic [63:0]      gen_rd, ivt_rd, win_rd, tbl_rd, ivt_wd;

  // Named access events
  logic addr_acc, data_acc, data_ok, data_bad, wr_gen, wr_ivt, wr_win;

  assign addr_acc = acc_en && !acc_sel;
  assign data_acc = acc_en && acc_sel;
  assign data_ok  = data_acc && known;
  assign data_bad = data_acc && !known;
  assign wr_gen   = data_ok && acc_wr && hit_gen;
  assign wr_ivt   = data_ok && acc_wr && hit_ivt;
  assign wr_win   = data_ok && acc_wr && hit_win;
  assign ent      = idx_q & mask;
  assign ivt_wd   = ivt_keep(acc_wdata);

  itap_decode #(
    .GEN_DEPTH(GEN_DEPTH), .IVT_DEPTH(IVT_DEPTH),
    .STUB_DEPTH(STUB_DEPTH), .WIN_DEPTH(WIN_DEPTH)
  ) u_dec (
    .tsel(tsel_q), .known(known), .hit_gen(hit_gen),
    .hit_ivt(hit_ivt), .hit_win(hit_win), .mask(mask)
  );

  itap_bank #(.DEPTH(GEN_DEPTH)) u_gen (
    .clk(clk), .rst_n(rst_n), .we(wr_gen), .idx(ent[GEN_AW-1:0]),
    .wdata(acc_wdata), .rdata(gen_rd)
  );

  itap_bank #(.DEPTH(IVT_DEPTH)) u_ivt (
    .clk(clk), .rst_n(rst_n), .we(wr_ivt), .idx(ent[IVT_AW-1:0]),
    .wdata(ivt_wd), .rdata(ivt_rd)
  );

  itap_bank #(.DEPTH(WIN_DEPTH)) u_win (
    .clk(clk), .rst_n(rst_n), .we(wr_win), .idx(ent[WIN_AW-1:0]),
    .wdata(acc_wdata), .rdata(win_rd)
  );

  always_comb begin
    tbl_rd = '0;
    if (hit_gen)      tbl_rd = gen_rd;
    else if (hit_ivt) tbl_rd = ivt_rd;
    else if (hit_win) tbl_rd = win_rd;
  end

  // Address register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      tsel_q <= '0;
      ainc_q <= 1'b0;
    end else if (addr_acc && acc_wr) begin
      idx_q  <= acc_wdata[IDX_W-1:0];
      tsel_q <= acc_wdata[SEL_LSB +: SEL_W];
      ainc_q <= acc_wdata[AINC_BIT];
    end else if (data_ok && ainc_q) begin
      idx_q  <= idx_advance(idx_q, mask);
    end
  end

  // Read data, error and strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_rdata    <= '0;
      sel_err_o    <= 1'b0;
      ivt_upd_o    <= 1'b0;
      ivt_idx_o    <= '0;
      ivt_server_o <= '0;
      ivt_prio_o   <= '0;
      win_upd_o    <= 1'b0;
      win_idx_o    <= '0;
    end else begin
      sel_err_o <= data_bad;
      ivt_upd_o <= wr_ivt;
      win_upd_o <= wr_win;
      if (acc_en && !acc_wr)
        acc_rdata <= acc_sel ? tbl_rd : addr_image(idx_q, tsel_q, ainc_q);
      if (wr_ivt) begin
        ivt_idx_o    <= ent;
        ivt_server_o <= acc_wdata[SRV_LSB+2 +: SRVO_W];
        ivt_prio_o   <= acc_wdata[PRI_LSB +: PRI_W];
      end
      if (wr_win)
        win_idx_o <= ent;
    end
  end

  // Assertions
  assert_err_keeps_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_bad |=> $stable(idx_q) && $stable(tsel_q));

  assert_err_after_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err_o |-> $past(acc_en) && $past(acc_sel));

  assert_no_inc_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ainc_q) |=> $stable(idx_q));

  assert_ivt_strobe_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ivt_upd_o |-> $past(acc_en && acc_wr && acc_sel) && $past(tsel_q) == TBL_IVT);

  assert_win_strobe_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_upd_o |-> $past(acc_en && acc_wr && acc_sel) && $past(tsel_q) == TBL_WIN);

  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ivt_upd_o, win_upd_o, sel_err_o}));
endmodule

// File: tb/itap_top_tb.sv
module itap_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0, acc_sel = 1'b0;
  logic [63:0] acc_wdata = '0;
  logic [63:0] acc_rdata;
  logic        sel_err_o, ivt_upd_o, win_upd_o;
  logic [7:0]  ivt_idx_o, ivt_prio_o, win_idx_o;
  logic [13:0] ivt_server_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  itap_top u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .sel_err_o(sel_err_o), .ivt_upd_o(ivt_upd_o), .ivt_idx_o(ivt_idx_o),
    .ivt_server_o(ivt_server_o), .ivt_prio_o(ivt_prio_o),
    .win_upd_o(win_upd_o), .win_idx_o(win_idx_o)
  );

  // Bench model
  logic [63:0] gen_m [8];
  logic [63:0] ivt_m [8];
  logic [63:0] win_m [16];
  logic [7:0]  idx_m;
  logic [3:0]  tsel_m;
  bit          ainc_m;

  localparam logic [63:0] IVT_KEEP = 64'h0000_FFFF_00F0_FF00;

  function automatic logic [7:0] depth_mask(input logic [3:0] t);
    case (t)
      4'd0, 4'd1: return 8'd7;
      4'd2, 4'd3: return 8'd3;
      4'd4:       return 8'd15;
      default:    return 8'd0;
    endcase
  endfunction

  function automatic logic [63:0] img(input logic [7:0] i, input logic [3:0] t, input bit a);
    return {32'd0, a, 11'd0, t, 8'd0, i};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input bit sel, input bit wr, input logic [63:0] d, input string tag);
    logic [63:0] exp_rd;
    logic [7:0]  m, e;
    bit known, exp_ivt, exp_win;
    known   = tsel_m < 4'd5;
    m       = depth_mask(tsel_m);
    e       = idx_m & m;
    exp_rd  = '0;
    exp_ivt = 0;
    exp_win = 0;
    if (!sel) begin
      exp_rd = img(idx_m, tsel_m, ainc_m);
      if (wr) begin
        idx_m = d[7:0]; tsel_m = d[19:16]; ainc_m = d[31];
      end
    end else if (known) begin
      case (tsel_m)
        4'd0: if (wr) gen_m[e[2:0]] = d; else exp_rd = gen_m[e[2:0]];
        4'd1: if (wr) begin ivt_m[e[2:0]] = d & IVT_KEEP; exp_ivt = 1; end
              else exp_rd = ivt_m[e[2:0]];
        4'd4: if (wr) begin win_m[e[3:0]] = d; exp_win = 1; end
              else exp_rd = win_m[e[3:0]];
        default: ;
      endcase
      if (ainc_m) idx_m = (idx_m + 8'd1) & m;
    end
    @(negedge clk);
    acc_en = 1; acc_sel = sel; acc_wr = wr; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
    if (!wr) chk(tag, acc_rdata, exp_rd);
    chk("R6 err", {63'd0, sel_err_o}, {63'd0, sel && !known});
    chk("R8 ivt strobe", {63'd0, ivt_upd_o}, {63'd0, exp_ivt});
    chk("R9 win strobe", {63'd0, win_upd_o}, {63'd0, exp_win});
    if (exp_ivt) begin
      chk("R8 idx", {56'd0, ivt_idx_o}, {56'd0, e});
      chk("R8 server", {50'd0, ivt_server_o}, {50'd0, d[47:34]});
      chk("R8 prio", {56'd0, ivt_prio_o}, {56'd0, d[15:8]});
    end
    if (exp_win) chk("R9 idx", {56'd0, win_idx_o}, {56'd0, e});
  endtask

  task automatic set_addr(input logic [7:0] i, input logic [3:0] t, input bit a);
    access(0, 1, img(i, t, a), "R2");
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin gen_m[k] = '0; ivt_m[k] = '0; end
    for (int k = 0; k < 16; k++) win_m[k] = '0;
    idx_m = '0; tsel_m = '0; ainc_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", acc_rdata, 64'd0);
    chk("R1 strobes", {61'd0, ivt_upd_o, win_upd_o, sel_err_o}, 64'd0);
    access(0, 0, 64'd0, "R1 addr");
    // R2 field positions, stray bits dropped
    access(0, 1, 64'hFFFF_FFFF_7FF5_FF2A, "R2");
    access(0, 0, 64'd0, "R2 readback");
    // R3 general table with index masking (0x0B -> entry 3)
    set_addr(8'h0B, 4'd0, 0);
    access(1, 1, 64'hDEAD_BEEF_0123_4567, "R3");
    set_addr(8'h03, 4'd0, 0);
    access(1, 0, 64'd0, "R3 masked index");
    // R7/R8 interrupt-vector masking and strobe
    set_addr(8'h05, 4'd1, 0);
    access(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    access(1, 0, 64'd0, "R7 readback");
    access(1, 1, 64'h1234_ABCD_5678_9A00, "R8");
    // R8 pulse is one cycle: low after an idle cycle
    @(negedge clk);
    chk("R8 pulse width", {63'd0, ivt_upd_o}, 64'd0);
    // R4/R9 window autoinc across wrap 15 -> 0
    set_addr(8'h0E, 4'd4, 1);
    for (int k = 0; k < 4; k++) access(1, 1, 64'hA5A5_0000_0000_0000 + 64'(k), "R9");
    access(0, 0, 64'd0, "R4 index after wrap");
    set_addr(8'h0E, 4'd4, 1);
    for (int k = 0; k < 4; k++) access(1, 0, 64'd0, "R3 window");
    // R10 read and address access raise no strobes (checked inside access)
    // R5 unbuilt tables: zero and wrap 3 -> 0
    set_addr(8'h02, 4'd2, 1);
    access(1, 1, 64'hFFFF_0000_FFFF_0000, "R5");
    access(1, 0, 64'd0, "R5 read zero");
    access(1, 0, 64'd0, "R5 read zero");
    access(0, 0, 64'd0, "R4 stub wrap");
    // R6 unknown select with autoinc
    set_addr(8'h21, 4'd9, 1);
    access(1, 1, 64'h1111_2222_3333_4444, "R6");
    access(1, 0, 64'd0, "R6 read zero");
    access(0, 0, 64'd0, "R6 index held");
    // Random phase
    void'($urandom(32'h1357));
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 0)
        set_addr(8'($urandom_range(0, 40)), 4'($urandom_range(0, 7)), bit'($urandom_range(0, 1)));
      else if (op == 1)
        access(0, 0, 64'd0, "R2 rnd");
      else if (op < 6)
        access(1, 1, {$urandom, $urandom}, "R10 rnd");
      else
        access(1, 0, 64'd0, "R3 rnd");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule